// File: doc/BRIEF.md
# Private Stack Engine

This block gives a 16-bit processor a stack with its own storage and its own stack pointer, reached only from the register side. Push, pop and pointer-relative accesses go to this storage, so the main instruction and data bus stays free for fetches and ordinary memory traffic in the same cycle.

The register side issues at most one command per cycle. A command is a 3-bit opcode, a 16-bit data word and a 16-bit signed offset. The engine can reset the pointer, return it, load it, push, pop, add a signed offset to it, and read or write the word at pointer plus offset without moving the pointer. The `GROW_DOWN` parameter sets the growth direction. `ADDR_W` sets the number of storage slots, which is 2^ADDR_W. Reads come back one cycle after the command, together with a valid strobe. While a read result is on the output, the engine lowers its ready signal and takes no new command.

Top module: `stk_engine`

## Requirements
- R1: During reset (`rst` high), and in the cycle after a reset-pointer command (`cmd_op`=0), `sp` reads 0xFFFF when `GROW_DOWN`=1 and 0x0000 when `GROW_DOWN`=0. After reset, `rd_valid`, `ovf` and `unf` are 0 and `cmd_ready` is 1.
- R2: Push (`cmd_op`=3) moves `sp` one step in the growth direction: minus 1 when growing down, plus 1 when growing up. It then stores `cmd_data` at the new `sp`. A storage slot is selected by the low `ADDR_W` bits of its 16-bit address.
- R3: Pop (`cmd_op`=4) reads the word at the current `sp`. The word appears on `rd_data` with `rd_valid` high in the next cycle. `sp` moves one step against the growth direction.
- R4: Read-pointer (`cmd_op`=1) returns the current `sp` on `rd_data` with `rd_valid` high in the next cycle. `sp` does not change.
- R5: Write-pointer (`cmd_op`=2) loads `sp` from `cmd_data`.
- R6: Adjust (`cmd_op`=5) adds `cmd_off` to `sp`, treated as signed and wrapping modulo 2^16.
- R7: Relative read (`cmd_op`=6) returns the word at `sp`+`cmd_off` one cycle later, with `rd_valid` high. `sp` does not change.
- R8: Relative write (`cmd_op`=7) stores `cmd_data` at `sp`+`cmd_off`. `sp` does not change.
- R9: Occupancy is the distance of `sp` from its reset value in the growth direction, taken modulo 2^16. A push when occupancy is at least 2^ADDR_W sets `ovf` for exactly one cycle. That push stores nothing and leaves `sp` unchanged.
- R10: A pop when occupancy is 0 sets `unf` for exactly one cycle. It leaves `sp` unchanged and produces no `rd_valid`.
- R11: `cmd_ready` is low in every cycle in which `rd_valid` is high. A command presented in such a cycle is ignored: `sp` and the storage are left unchanged, and no flag or read result follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 16 | Push data, new pointer value or relative write data |
| cmd_off | input | 16 | Signed offset for adjust and relative access |
| cmd_ready | output | 1 | The engine accepts a command this cycle |
| rd_valid | output | 1 | `rd_data` holds a pop, relative-read or pointer result |
| rd_data | output | 16 | Read result |
| sp | output | 16 | Current stack pointer |
| ovf | output | 1 | One-cycle pulse: a push was refused |
| unf | output | 1 | One-cycle pulse: a pop was refused |

## Verification
The assertions assume `rst` is driven to a known level from the first edge, and that `cmd_op` is never unknown while `cmd_valid` is high. The bench meets both: it holds reset over the first edges and drives every command input before it raises `cmd_valid`. Pop and relative read return storage contents, so the read checks assume every slot has been written first. The bench fills the stack completely before any relative read and before any pop that could reach an unwritten slot. Only one stimulus deliberately breaks the ready handshake, and it is there to show that the held-off command has no effect.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STK_W = 16;

    typedef enum logic [2:0] {
        OP_RST   = 3'd0,
        OP_RDSP  = 3'd1,
        OP_WRSP  = 3'd2,
        OP_PUSH  = 3'd3,
        OP_POP   = 3'd4,
        OP_ADJ   = 3'd5,
        OP_RDREL = 3'd6,
        OP_WRREL = 3'd7
    } stk_op_e;

    typedef struct packed {
        logic             we;
        logic             re;
        logic [STK_W-1:0] addr;
        logic [STK_W-1:0] wdata;
    } stk_req_t;

    function automatic logic [STK_W-1:0] f_home(input bit grow_down);
        return grow_down ? {STK_W{1'b1}} : {STK_W{1'b0}};
    endfunction

    function automatic logic [STK_W-1:0] f_step(input bit grow_down);
        return grow_down ? {STK_W{1'b1}} : STK_W'(1);
    endfunction

endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int ADDR_W = 8,
    parameter int W      = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter bit GROW_DOWN = 1'b1,
    parameter int ADDR_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  stk_op_e          op,
    input  logic [STK_W-1:0] data,
    input  logic [STK_W-1:0] off,
    output logic [STK_W-1:0] ptr,
    output stk_req_t         req,
    output logic             ovf_hit,
    output logic             unf_hit,
    output logic             rdsp_hit
);
    localparam logic [STK_W-1:0] HOME  = f_home(GROW_DOWN);
    localparam logic [STK_W-1:0] STEP  = f_step(GROW_DOWN);
    localparam logic [STK_W:0]   SLOTS = (STK_W+1)'(1) << ADDR_W;

    logic [STK_W-1:0] ptr_q, ptr_d, occ, ahead, behind, rel;
    logic             full, empty;

    always_comb begin
        occ    = GROW_DOWN ? (HOME - ptr_q) : (ptr_q - HOME);
        full   = {1'b0, occ} >= SLOTS;
        empty  = (occ == '0);
        ahead  = ptr_q + STEP;
        behind = ptr_q - STEP;
        rel    = ptr_q + off;
    end

    always_comb begin
        ptr_d    = ptr_q;
        req      = '0;
        ovf_hit  = 1'b0;
        unf_hit  = 1'b0;
        rdsp_hit = 1'b0;
        if (acc) begin
            case (op)
                OP_RST:  ptr_d = HOME;
                OP_RDSP: rdsp_hit = 1'b1;
                OP_WRSP: ptr_d = data;
                OP_PUSH: begin
                    if (full) ovf_hit = 1'b1;
                    else begin
                        ptr_d     = ahead;
                        req.we    = 1'b1;
                        req.addr  = ahead;
                        req.wdata = data;
                    end
                end
                OP_POP: begin
                    if (empty) unf_hit = 1'b1;
                    else begin
                        ptr_d    = behind;
                        req.re   = 1'b1;
                        req.addr = ptr_q;
                    end
                end
                OP_ADJ:  ptr_d = rel;
                OP_RDREL: begin
                    req.re   = 1'b1;
                    req.addr = rel;
                end
                OP_WRREL: begin
                    req.we    = 1'b1;
                    req.addr  = rel;
                    req.wdata = data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= HOME;
        else     ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R9: a refused push keeps the pointer where it was
    a_r9_hold_on_full: assert property (@(posedge clk) disable iff (rst)
        ovf_hit |=> (ptr_q == $past(ptr_q)));

    // R10: a refused pop keeps the pointer where it was
    a_r10_hold_on_empty: assert property (@(posedge clk) disable iff (rst)
        unf_hit |=> (ptr_q == $past(ptr_q)));

endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter bit GROW_DOWN = 1'b1,
    parameter int ADDR_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [STK_W-1:0] cmd_data,
    input  logic [STK_W-1:0] cmd_off,
    output logic             cmd_ready,
    output logic             rd_valid,
    output logic [STK_W-1:0] rd_data,
    output logic [STK_W-1:0] sp,
    output logic             ovf,
    output logic             unf
);
    localparam logic [STK_W-1:0] HOME = f_home(GROW_DOWN);
    localparam logic [STK_W-1:0] STEP = f_step(GROW_DOWN);

    stk_op_e          op;
    stk_req_t         req;
    logic             acc, ovf_hit, unf_hit, rdsp_hit, from_ptr;
    logic [STK_W-1:0] ptr_cap, mem_q;

    assign op        = stk_op_e'(cmd_op);
    assign cmd_ready = !rd_valid;
    assign acc       = cmd_valid && cmd_ready;

    stk_ptr #(.GROW_DOWN(GROW_DOWN), .ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .acc(acc), .op(op),
        .data(cmd_data), .off(cmd_off), .ptr(sp), .req(req),
        .ovf_hit(ovf_hit), .unf_hit(unf_hit), .rdsp_hit(rdsp_hit)
    );

    stk_ram #(.ADDR_W(ADDR_W), .W(STK_W)) u_ram (
        .clk(clk), .we(req.we), .re(req.re),
        .addr(req.addr[ADDR_W-1:0]), .wdata(req.wdata), .rdata(mem_q)
    );

    generate
        if (ADDR_W < STK_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^req.addr[STK_W-1:ADDR_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            from_ptr <= 1'b0;
            ptr_cap  <= '0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            rd_valid <= req.re || rdsp_hit;
            from_ptr <= rdsp_hit;
            if (rdsp_hit) ptr_cap <= sp;
            ovf <= ovf_hit;
            unf <= unf_hit;
        end
    end

    assign rd_data = from_ptr ? ptr_cap : mem_q;

    // R1: the pointer returns home through reset
    a_r1_reset_home: assert property (@(posedge clk)
        rst |=> (sp == HOME && !rd_valid && !ovf && !unf));

    // R2: an accepted push either moves one step or is refused
    a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_PUSH) |=> (ovf || sp == STK_W'($past(sp) + STEP)));

    // R3: an accepted pop either returns data and steps back or is refused
    a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_POP) |=> (unf || (rd_valid && sp == STK_W'($past(sp) - STEP))));

    // R7: a relative read answers next cycle and leaves the pointer alone
    a_r7_rel_read: assert property (@(posedge clk) disable iff (rst)
        (acc && op == OP_RDREL) |=> (rd_valid && $stable(sp)));

    // R11: a held-off command changes nothing
    a_r11_held_off: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> ($stable(sp) && !ovf && !unf && !rd_valid));

endmodule

// File: tb/stk_engine_bench.sv
`timescale 1ns/1ps
module stk_engine_bench;
    localparam int AW  = 4;
    localparam int DEP = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, cv;
    logic [2:0]  op;
    logic [15:0] dat, off;
    logic        rdy [2];
    logic        rv  [2];
    logic        ov  [2];
    logic        un  [2];
    logic [15:0] rd  [2];
    logic [15:0] sp  [2];

    stk_engine #(.GROW_DOWN(1'b1), .ADDR_W(AW)) u_stk_engine (
        .clk(clk), .rst(rst), .cmd_valid(cv), .cmd_op(op), .cmd_data(dat),
        .cmd_off(off), .cmd_ready(rdy[0]), .rd_valid(rv[0]), .rd_data(rd[0]),
        .sp(sp[0]), .ovf(ov[0]), .unf(un[0])
    );

    stk_engine #(.GROW_DOWN(1'b0), .ADDR_W(AW)) u_stk_engine_up (
        .clk(clk), .rst(rst), .cmd_valid(cv), .cmd_op(op), .cmd_data(dat),
        .cmd_off(off), .cmd_ready(rdy[1]), .rd_valid(rv[1]), .rd_data(rd[1]),
        .sp(sp[1]), .ovf(ov[1]), .unf(un[1])
    );

    logic [15:0] m_sp  [2];
    logic [15:0] m_mem [2][DEP];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] home(input int u);
        return (u == 0) ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic logic [15:0] stp(input int u);
        return (u == 0) ? 16'hFFFF : 16'h0001;
    endfunction

    // issue one command; with hold=1 a push is presented in the busy cycle (R11)
    task automatic do_cmd(input logic [2:0] o, input logic [15:0] d,
                          input logic [15:0] f, input string tag, input bit hold = 0);
        logic [15:0] e_rd [2];
        bit e_rv [2];
        bit e_ov [2];
        bit e_un [2];
        for (int u = 0; u < 2; u++) begin
            logic [15:0] occ, a;
            occ = (u == 0) ? home(u) - m_sp[u] : m_sp[u] - home(u);
            e_rd[u] = 16'h0; e_rv[u] = 0; e_ov[u] = 0; e_un[u] = 0;
            case (o)
                3'd0: m_sp[u] = home(u);
                3'd1: begin e_rv[u] = 1; e_rd[u] = m_sp[u]; end
                3'd2: m_sp[u] = d;
                3'd3: if (occ >= DEP) e_ov[u] = 1;
                      else begin
                          m_sp[u] = m_sp[u] + stp(u);
                          m_mem[u][m_sp[u][AW-1:0]] = d;
                      end
                3'd4: if (occ == 0) e_un[u] = 1;
                      else begin
                          e_rv[u] = 1; e_rd[u] = m_mem[u][m_sp[u][AW-1:0]];
                          m_sp[u] = m_sp[u] - stp(u);
                      end
                3'd5: m_sp[u] = m_sp[u] + f;
                3'd6: begin
                    a = m_sp[u] + f;
                    e_rv[u] = 1; e_rd[u] = m_mem[u][a[AW-1:0]];
                end
                default: begin
                    a = m_sp[u] + f;
                    m_mem[u][a[AW-1:0]] = d;
                end
            endcase
        end
        op = o; dat = d; off = f; cv = 1'b1;
        @(posedge clk); @(negedge clk);
        if (hold) begin op = 3'd3; dat = 16'hDEAD; end
        else cv = 1'b0;
        for (int u = 0; u < 2; u++) begin
            chk({tag, " sp"}, sp[u], m_sp[u]);
            chk({tag, " rd_valid"}, 16'(rv[u]), 16'(e_rv[u]));
            chk({tag, " R11 ready"}, 16'(rdy[u]), 16'(!e_rv[u]));
            chk({tag, " R9 ovf"}, 16'(ov[u]), 16'(e_ov[u]));
            chk({tag, " R10 unf"}, 16'(un[u]), 16'(e_un[u]));
            if (e_rv[u]) chk({tag, " rd_data"}, rd[u], e_rd[u]);
        end
        @(posedge clk); @(negedge clk);
        cv = 1'b0;
        if (hold)
            for (int u = 0; u < 2; u++) begin
                chk("R11 held-off push sp", sp[u], m_sp[u]);
                chk("R11 held-off push ovf", 16'(ov[u]), 16'h0);
                chk("R11 held-off push rd_valid", 16'(rv[u]), 16'h0);
            end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cv = 1'b0; op = 3'd0; dat = 16'h0; off = 16'h0;
        for (int u = 0; u < 2; u++) m_sp[u] = home(u);
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            chk("R1 reset sp", sp[u], home(u));
            chk("R1 reset rd_valid", 16'(rv[u]), 16'h0);
            chk("R1 reset ready", 16'(rdy[u]), 16'h1);
            chk("R1 reset flags", 16'({ov[u], un[u]}), 16'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        do_cmd(3'd4, 16'h0, 16'h0, "R10 pop empty");
        for (int i = 0; i < DEP; i++)
            do_cmd(3'd3, 16'h1000 + 16'(i * 37), 16'h0, "R2 push fill");
        do_cmd(3'd3, 16'hBEEF, 16'h0, "R9 push full");
        do_cmd(3'd1, 16'h0, 16'h0, "R4 read ptr");
        for (int k = -20; k <= 20; k++)
            do_cmd(3'd6, 16'h0, 16'(k), "R7 rel read");
        for (int k = -3; k <= 3; k++)
            do_cmd(3'd7, 16'hA500 + 16'(k + 3), 16'(k), "R8 rel write");
        for (int k = -3; k <= 3; k++)
            do_cmd(3'd6, 16'h0, 16'(k), "R8 rel readback");
        for (int i = 0; i < DEP; i++)
            do_cmd(3'd4, 16'h0, 16'h0, "R3 pop", i == 3);
        do_cmd(3'd4, 16'h0, 16'h0, "R10 pop past home");
        do_cmd(3'd5, 16'h0, 16'h0005, "R6 adjust plus");
        do_cmd(3'd5, 16'h0, 16'hFFFD, "R6 adjust minus");
        do_cmd(3'd1, 16'h0, 16'h0, "R6 R4 read ptr");
        do_cmd(3'd2, 16'h1234, 16'h0, "R5 write ptr");
        do_cmd(3'd1, 16'h0, 16'h0, "R5 read ptr");
        do_cmd(3'd3, 16'h7777, 16'h0, "R9 push far from home");
        do_cmd(3'd4, 16'h0, 16'h0, "R3 pop after load");
        do_cmd(3'd0, 16'h0, 16'h0, "R1 reset command");
        do_cmd(3'd4, 16'h0, 16'h0, "R1 R10 pop after reset command");
        do_cmd(3'd3, 16'h4242, 16'h0, "R2 push after reset command");
        do_cmd(3'd4, 16'h0, 16'h0, "R3 pop after reset command");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule